// File: doc/BRIEF.md
# Predicated widening vector multiplier

This block multiplies narrow integer lanes drawn from two 128-bit source vectors and returns lanes twice as wide. Only half of the source lanes take part in one operation: either the even-numbered ones (bottom form) or the odd-numbered ones (top form). Each operand is widened, by sign or zero extension, to the result lane width before the multiply, so no product bits are lost. Source lanes may be 8, 16 or 32 bits wide, giving 8, 4 or 2 result lanes of 16, 32 or 64 bits.

The result is not written whole. A 16-bit predicate with one bit per destination byte decides, byte by byte, whether the product byte or the matching byte of the old destination value appears at the output. The block decodes the 32-bit instruction word itself. It reports whether the word is one of the four widening-multiply forms, reports whether the size field is reserved, and returns the three vector register numbers. The merged result is registered once and appears with a valid strobe one clock after the request.

Top module: `wvm_top`

## Requirements
- R1: `dec_match` is 1 exactly when `(insn & 32'hEF810F51) == 32'hEE010E00`. Bits 22, 7 and 5 do not affect matching.
- R2: For a matching word, the register numbers are `dec_qd = insn[15:13]`, `dec_qn = insn[19:17]` and `dec_qm = insn[3:1]`. Within the operation, `insn[21:20]` is the size code, `insn[28]=1` selects unsigned operands and `insn[12]=1` selects the top (odd) lanes.
- R3: For a matching word with size code 3, `dec_undef` is 1, no valid output follows, and `result` keeps its previous value. For any other word, `dec_undef` is 0.
- R4: A request (`in_valid=1`) whose word does not match gives no valid output and leaves `result` unchanged.
- R5: Result lane i is computed from source lane 2*i+T of both `src_a` and `src_b`, where T is `insn[12]`.
- R6: Signed forms sign-extend both operands to the result width and unsigned forms zero-extend them. The full double-width product is kept.
- R7: Size codes 0, 1 and 2 select 8-, 16- and 32-bit source lanes, producing 8, 4 and 2 result lanes. Lanes are little-endian: lane 0 sits in the least significant bits.
- R8: Output byte k equals product byte k when `pred[k]=1` and `old_dst` byte k when `pred[k]=0`.
- R9: An accepted request (valid, matching, size code 0 to 2) raises `out_valid` on the next rising edge with the merged value on `result`. In any cycle with no accepted request, `out_valid` is 0 on the next edge and `result` holds its value.
- R10: A synchronous reset clears `out_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word to decode |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| old_dst | input | 128 | Prior destination contents for masked bytes |
| pred | input | 16 | Per-byte write predicate |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| result | output | 128 | Registered merged result |
| dec_match | output | 1 | Word is a widening-multiply form |
| dec_undef | output | 1 | Matching word with reserved size code |
| dec_qd | output | 3 | Destination register number |
| dec_qn | output | 3 | First source register number |
| dec_qm | output | 3 | Second source register number |

## Verification
The assertions assume that `in_valid`, `insn`, `pred` and the vectors are stable and known around each rising edge. They also assume that the cycles just after reset carry no leftover request. The bench drives every input at the falling edge and holds it for a whole cycle. It releases reset only with `in_valid` low, and it draws its random instruction words from the four legal forms with the don't-care bits randomised. Reserved sizes and non-matching words appear only in directed cases whose expected outcome is fixed.

// File: rtl/wvm_pkg.sv
package wvm_pkg;

   // fixed opcode bits of the four widening-multiply forms
   localparam logic [31:0] WVM_FIX_MASK = 32'hEF81_0F51;
   localparam logic [31:0] WVM_FIX_VAL  = 32'hEE01_0E00;

   // field positions inside the instruction word
   localparam int WVM_POS_UNS  = 28;
   localparam int WVM_POS_SZ   = 20;
   localparam int WVM_POS_QN   = 17;
   localparam int WVM_POS_QD   = 13;
   localparam int WVM_POS_TOP  = 12;
   localparam int WVM_POS_QM   = 1;
   localparam logic [1:0] WVM_SZ_RESERVED = 2'd3;

   typedef struct packed {
      logic       match;
      logic       undef;
      logic       is_unsigned;
      logic       is_top;
      logic [1:0] size;
      logic [2:0] qd;
      logic [2:0] qn;
      logic [2:0] qm;
   } wvm_dec_t;

endpackage

// File: rtl/wvm_decode.sv
module wvm_decode
   import wvm_pkg::*;
(
   input  logic [31:0] insn,
   output wvm_dec_t    dec
);

   logic hit;

   assign hit = ((insn & WVM_FIX_MASK) == WVM_FIX_VAL);

   always_comb begin
      dec             = '0;
      dec.match       = hit;
      dec.size        = insn[WVM_POS_SZ +: 2];
      dec.undef       = hit && (insn[WVM_POS_SZ +: 2] == WVM_SZ_RESERVED);
      dec.is_unsigned = insn[WVM_POS_UNS];
      dec.is_top      = insn[WVM_POS_TOP];
      dec.qd          = insn[WVM_POS_QD +: 3];
      dec.qn          = insn[WVM_POS_QN +: 3];
      dec.qm          = insn[WVM_POS_QM +: 3];
   end

endmodule

// File: rtl/wvm_lane_mul.sv
module wvm_lane_mul #(
   parameter int SRC_W = 8
) (
   input  logic [SRC_W-1:0]   op_a,
   input  logic [SRC_W-1:0]   op_b,
   input  logic               signed_op,
   output logic [2*SRC_W-1:0] prod
);

   localparam int DST_W = 2 * SRC_W;

   logic signed [DST_W-1:0] ext_a;
   logic signed [DST_W-1:0] ext_b;

   assign ext_a = {{SRC_W{signed_op & op_a[SRC_W-1]}}, op_a};
   assign ext_b = {{SRC_W{signed_op & op_b[SRC_W-1]}}, op_b};
   assign prod  = ext_a * ext_b;

   // R6: a nonzero signed product carries the xor of the operand signs
   always_comb begin
      if (signed_op && (op_a != '0) && (op_b != '0)) begin
         a_r6_sign_of_product: assert (prod[DST_W-1] == (op_a[SRC_W-1] ^ op_b[SRC_W-1]));
      end
   end

endmodule

// File: rtl/wvm_size_lanes.sv
module wvm_size_lanes #(
   parameter int VEC_W = 128,
   parameter int SRC_W = 8
) (
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             use_top,
   input  logic             signed_op,
   output logic [VEC_W-1:0] prod_vec
);

   localparam int DST_W   = 2 * SRC_W;
   localparam int N_LANES = VEC_W / DST_W;

   generate
      if (VEC_W % DST_W != 0) begin : g_bad_width
         $error("wvm_size_lanes: vector width must be a multiple of the result lane width");
      end
   endgenerate

   for (genvar li = 0; li < N_LANES; li++) begin : g_lane
      logic [SRC_W-1:0] a_pick;
      logic [SRC_W-1:0] b_pick;

      // even lane 2*li or odd lane 2*li+1
      assign a_pick = use_top ? src_a[(2*li+1)*SRC_W +: SRC_W] : src_a[(2*li)*SRC_W +: SRC_W];
      assign b_pick = use_top ? src_b[(2*li+1)*SRC_W +: SRC_W] : src_b[(2*li)*SRC_W +: SRC_W];

      wvm_lane_mul #(.SRC_W(SRC_W)) u_mul (
         .op_a      (a_pick),
         .op_b      (b_pick),
         .signed_op (signed_op),
         .prod      (prod_vec[li*DST_W +: DST_W])
      );
   end

endmodule

// File: rtl/wvm_byte_merge.sv
module wvm_byte_merge #(
   parameter int N_BYTES = 16
) (
   input  logic [8*N_BYTES-1:0] fresh,
   input  logic [8*N_BYTES-1:0] prior,
   input  logic [N_BYTES-1:0]   keep_n,
   output logic [8*N_BYTES-1:0] merged
);

   for (genvar bi = 0; bi < N_BYTES; bi++) begin : g_byte
      assign merged[8*bi +: 8] = keep_n[bi] ? fresh[8*bi +: 8] : prior[8*bi +: 8];
   end

endmodule

// File: rtl/wvm_top.sv
module wvm_top
   import wvm_pkg::*;
#(
   parameter int VEC_BYTES    = 16,
   parameter int MAX_SIZE_LOG = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [31:0]            insn,
   input  logic [8*VEC_BYTES-1:0] src_a,
   input  logic [8*VEC_BYTES-1:0] src_b,
   input  logic [8*VEC_BYTES-1:0] old_dst,
   input  logic [VEC_BYTES-1:0]   pred,
   output logic                   out_valid,
   output logic [8*VEC_BYTES-1:0] result,
   output logic                   dec_match,
   output logic                   dec_undef,
   output logic [2:0]             dec_qd,
   output logic [2:0]             dec_qn,
   output logic [2:0]             dec_qm
);

   localparam int VEC_W   = 8 * VEC_BYTES;
   localparam int N_SIZES = MAX_SIZE_LOG + 1;

   generate
      if (MAX_SIZE_LOG < 0 || MAX_SIZE_LOG > 2) begin : g_bad_sizes
         $error("wvm_top: size code field supports at most three lane sizes");
      end
      if (VEC_BYTES < (2 << MAX_SIZE_LOG)) begin : g_bad_vec
         $error("wvm_top: vector too narrow for the widest result lane");
      end
      if ((VEC_BYTES & (VEC_BYTES - 1)) != 0) begin : g_bad_pow2
         $error("wvm_top: vector byte count must be a power of two");
      end
   endgenerate

   wvm_dec_t dec;

   wvm_decode u_dec (
      .insn (insn),
      .dec  (dec)
   );

   assign dec_match = dec.match;
   assign dec_undef = dec.undef;
   assign dec_qd    = dec.qd;
   assign dec_qn    = dec.qn;
   assign dec_qm    = dec.qm;

   logic [VEC_W-1:0] prod_by_size [N_SIZES];

   for (genvar si = 0; si < N_SIZES; si++) begin : g_size
      wvm_size_lanes #(
         .VEC_W (VEC_W),
         .SRC_W (8 << si)
      ) u_lanes (
         .src_a     (src_a),
         .src_b     (src_b),
         .use_top   (dec.is_top),
         .signed_op (~dec.is_unsigned),
         .prod_vec  (prod_by_size[si])
      );
   end

   logic [VEC_W-1:0] prod_sel;
   logic             size_ok;

   always_comb begin
      prod_sel = prod_by_size[0];
      size_ok  = 1'b0;
      for (int si = 0; si < N_SIZES; si++) begin
         if (dec.size == 2'(si)) begin
            prod_sel = prod_by_size[si];
            size_ok  = 1'b1;
         end
      end
   end

   logic [VEC_W-1:0] merged;

   wvm_byte_merge #(.N_BYTES(VEC_BYTES)) u_merge (
      .fresh  (prod_sel),
      .prior  (old_dst),
      .keep_n (pred),
      .merged (merged)
   );

   logic accept;
   assign accept = in_valid && dec.match && !dec.undef && size_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            result <= merged;
         end
      end
   end

   // R10: reset clears the output stage
   a_r10_reset_clears: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));

   // R9: a legal request is answered one edge later
   a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec_match && !dec_undef && insn[WVM_POS_SZ +: 2] <= 2'(MAX_SIZE_LOG)) |=> out_valid);

   // R9: result holds when nothing is accepted
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && dec_match && !dec_undef) |=> (!out_valid && $stable(result)));

   // R3: a reserved size never produces output
   a_r3_reserved_silent: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec_undef) |=> !out_valid);

   // R4: a non-matching word never produces output
   a_r4_nomatch_silent: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !dec_match) |=> !out_valid);

   // R8: bytes with a clear predicate bit come from the old destination
   for (genvar bk = 0; bk < VEC_BYTES; bk++) begin : g_keep_chk
      a_r8_masked_byte: assert property (@(posedge clk) disable iff (rst)
         (out_valid && !$past(pred[bk])) |-> (result[8*bk +: 8] == $past(old_dst[8*bk +: 8])));
   end

endmodule

// File: tb/tb_wvm_top.sv
`timescale 1ns/1ps
module tb_wvm_top;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [31:0]  insn;
   logic [127:0] src_a, src_b, old_dst;
   logic [15:0]  pred;
   logic         out_valid;
   logic [127:0] result;
   logic         dec_match, dec_undef;
   logic [2:0]   dec_qd, dec_qn, dec_qm;

   always #2.5 clk = ~clk;

   wvm_top dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .insn      (insn),
      .src_a     (src_a),
      .src_b     (src_b),
      .old_dst   (old_dst),
      .pred      (pred),
      .out_valid (out_valid),
      .result    (result),
      .dec_match (dec_match),
      .dec_undef (dec_undef),
      .dec_qd    (dec_qd),
      .dec_qn    (dec_qn),
      .dec_qm    (dec_qm)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   logic [127:0] exp_hold;

   task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_insn(input bit uns, input bit top, input logic [1:0] sz,
                                           input logic [2:0] qd, input logic [2:0] qn,
                                           input logic [2:0] qm, input logic [2:0] dontcare);
      logic [31:0] w;
      w = 32'hEE01_0E00;
      w[28] = uns;
      w[21:20] = sz;
      w[19:17] = qn;
      w[15:13] = qd;
      w[12] = top;
      w[3:1] = qm;
      w[22] = dontcare[2];
      w[7]  = dontcare[1];
      w[5]  = dontcare[0];
      return w;
   endfunction

   // expected merged value from the requirements (R5, R6, R7, R8)
   function automatic logic [127:0] model(input bit uns, input bit top, input logic [1:0] sz,
                                          input logic [127:0] a, input logic [127:0] b,
                                          input logic [127:0] old, input logic [15:0] p);
      logic [127:0] prod;
      logic [127:0] res;
      int w;
      int nl;
      prod = '0;
      w  = 8 << sz;
      nl = 128 / (2 * w);
      for (int i = 0; i < nl; i++) begin
         logic [63:0] m, ea, eb, pr;
         m  = (w == 64) ? ~64'd0 : ((64'd1 << w) - 64'd1);
         ea = 64'(a >> ((2 * i + int'(top)) * w)) & m;
         eb = 64'(b >> ((2 * i + int'(top)) * w)) & m;
         if (!uns && ea[w-1]) ea = ea | ~m;
         if (!uns && eb[w-1]) eb = eb | ~m;
         pr = ea * eb;
         if (2 * w < 64) pr = pr & ((64'd1 << (2 * w)) - 64'd1);
         prod = prod | (128'(pr) << (i * 2 * w));
      end
      for (int k = 0; k < 16; k++) begin
         res[8*k +: 8] = p[k] ? prod[8*k +: 8] : old[8*k +: 8];
      end
      return res;
   endfunction

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // one request; exp_ok tells whether it must be accepted
   task automatic run_op(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] old, input logic [15:0] p, input bit exp_ok,
                         input string tag);
      logic [127:0] exp;
      @(negedge clk);
      insn = w; src_a = a; src_b = b; old_dst = old; pred = p; in_valid = 1'b1;
      if (exp_ok) exp = model(w[28], w[12], w[21:20], a, b, old, p);
      else        exp = exp_hold;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == exp_ok, {tag, " valid"}, 128'(out_valid), 128'(exp_ok));
      check(result == exp, {tag, " data"}, result, exp);
      exp_hold = exp;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; in_valid = 1'b1;
      insn = mk_insn(0, 0, 2'd0, 3'd1, 3'd2, 3'd3, 3'd0);
      src_a = '1; src_b = '1; old_dst = '1; pred = '1;
      repeat (3) @(negedge clk);
      // R10: reset state even with a live request held
      check(out_valid == 1'b0, "R10 reset valid", 128'(out_valid), 128'd0);
      check(result == '0, "R10 reset data", result, 128'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      exp_hold = '0;

      // R1 and R2: decode with don't-care bits randomised
      for (int n = 0; n < 40; n++) begin
         logic [31:0] w;
         logic [2:0] qd, qn, qm;
         logic [1:0] sz;
         qd = 3'($urandom); qn = 3'($urandom); qm = 3'($urandom); sz = 2'($urandom);
         w = mk_insn(1'($urandom), 1'($urandom), sz, qd, qn, qm, 3'($urandom));
         insn = w;
         #1;
         check(dec_match == 1'b1, "R1 match", 128'(dec_match), 128'd1);
         check({dec_qd, dec_qn, dec_qm} == {qd, qn, qm}, "R2 fields",
               128'({dec_qd, dec_qn, dec_qm}), 128'({qd, qn, qm}));
         check(dec_undef == (sz == 2'd3), "R3 undef flag", 128'(dec_undef), 128'(sz == 2'd3));
      end
      // R1: flipping any fixed bit breaks the match
      for (int bpos = 0; bpos < 32; bpos++) begin
         if (32'hEF81_0F51 & (32'd1 << bpos)) begin
            insn = mk_insn(0, 1, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0) ^ (32'd1 << bpos);
            #1;
            check(dec_match == 1'b0, "R1 nomatch", 128'(dec_match), 128'd0);
            check(dec_undef == 1'b0, "R3 undef only on match", 128'(dec_undef), 128'd0);
         end
      end

      // R6 and R7: extremes in every form and size, full predicate
      for (int f = 0; f < 12; f++) begin
         run_op(mk_insn(f[0], f[1], 2'(f / 4), 3'd0, 3'd1, 3'd2, 3'd0),
                {16{8'h80}}, {16{8'hFF}}, '0, 16'hFFFF, 1'b1, "R6 R7 extremes");
         run_op(mk_insn(f[0], f[1], 2'(f / 4), 3'd0, 3'd1, 3'd2, 3'd0),
                {16{8'h80}}, {16{8'h80}}, '0, 16'hFFFF, 1'b1, "R6 R7 min squared");
      end
      // R5: distinct even and odd lanes so the selection shows
      run_op(mk_insn(1, 0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0), {8{8'h05, 8'h03}}, {8{8'h07, 8'h02}},
             '0, 16'hFFFF, 1'b1, "R5 bottom lanes");
      check(result[15:0] == 16'd6, "R5 bottom lane0", 128'(result[15:0]), 128'd6);
      run_op(mk_insn(1, 1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0), {8{8'h05, 8'h03}}, {8{8'h07, 8'h02}},
             '0, 16'hFFFF, 1'b1, "R5 top lanes");
      check(result[15:0] == 16'd35, "R5 top lane0", 128'(result[15:0]), 128'd35);

      // R8: all bytes masked, then alternate bytes
      run_op(mk_insn(0, 0, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0), rnd128(), rnd128(), rnd128(),
             16'h0000, 1'b1, "R8 all masked");
      run_op(mk_insn(0, 1, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0), rnd128(), rnd128(), rnd128(),
             16'hA5C3, 1'b1, "R8 partial mask");

      // R3: reserved size yields nothing and result holds
      run_op(mk_insn(0, 0, 2'd3, 3'd0, 3'd0, 3'd0, 3'd0), rnd128(), rnd128(), rnd128(),
             16'hFFFF, 1'b0, "R3 reserved size");
      // R4: non-matching word yields nothing and result holds
      run_op(mk_insn(1, 0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0) ^ 32'h0001_0000, rnd128(), rnd128(),
             rnd128(), 16'hFFFF, 1'b0, "R4 nonmatching word");

      // R9: back-to-back requests, one result per edge
      @(negedge clk);
      begin
         logic [127:0] a1, b1, o1, e1;
         a1 = rnd128(); b1 = rnd128(); o1 = rnd128();
         e1 = model(1'b0, 1'b1, 2'd0, a1, b1, o1, 16'h0FF0);
         insn = mk_insn(0, 1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0);
         src_a = a1; src_b = b1; old_dst = o1; pred = 16'h0FF0; in_valid = 1'b1;
         @(negedge clk);
         check(out_valid == 1'b1, "R9 first of pair", 128'(out_valid), 128'd1);
         check(result == e1, "R9 first data", result, e1);
         insn = mk_insn(1, 0, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0);
         e1 = model(1'b1, 1'b0, 2'd2, a1, b1, o1, 16'hFFFF);
         pred = 16'hFFFF;
         @(negedge clk);
         in_valid = 1'b0;
         check(out_valid == 1'b1, "R9 second of pair", 128'(out_valid), 128'd1);
         check(result == e1, "R9 second data", result, e1);
         exp_hold = e1;
         @(negedge clk);
         check(out_valid == 1'b0, "R9 idle after pair", 128'(out_valid), 128'd0);
         check(result == exp_hold, "R9 hold when idle", result, exp_hold);
      end

      // random legal traffic covering R5, R6, R7, R8
      for (int n = 0; n < 400; n++) begin
         run_op(mk_insn(1'($urandom), 1'($urandom), 2'($urandom_range(0, 2)), 3'($urandom),
                        3'($urandom), 3'($urandom), 3'($urandom)),
                rnd128(), rnd128(), rnd128(), 16'($urandom), 1'b1, "R5/R6/R7/R8 random");
      end

      // R10: reset in mid-stream clears a held result
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(out_valid == 1'b0, "R10 midstream valid", 128'(out_valid), 128'd0);
      check(result == '0, "R10 midstream data", result, 128'd0);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule